// File: doc/BRIEF.md
# Greedy Widest-Window Coefficient Decomposer

This block breaks an unsigned constant coefficient into a list of fragments, where each fragment is a small odd bit pattern (a symbol) shifted left by some amount. The fragments are meant to drive the adder network of a shift-and-add constant multiplier. The symbol set is fixed at five patterns: 1, 11, 101, 111 and 1001. Added together, the fragments rebuild the coefficient exactly.

A pulse on `start_i` while the block is idle loads the coefficient. The block then walks the value from its highest set bit down toward bit 0 and emits one fragment per clock.

At each step the block looks at windows that begin at the current top set bit. It tries window widths 4, 3, 2 and 1, in that order. It keeps the widest window whose bits equal a symbol exactly, reports that fragment, and clears the bits it covered. It never interleaves symbols and never searches for a globally better cover.

Top module: `lsg_decomposer`

## Requirements
- R1: After reset, `busy_o` and `frag_valid_o` are low.
- R2: A `start_i` pulse sampled while idle loads `coef_i`. The first fragment is valid in the cycle after that clock edge, and one fragment follows per cycle with no gaps.
- R3: `frag_sym_o` carries the symbol pattern as a plain value: 1, 3, 5, 7 or 9 (binary 1, 11, 101, 111, 1001). `frag_shift_o` is the bit position of the window's LSB.
- R4: At each step the widest window (4, then 3, 2, 1 bits) that starts at the current top set bit and equals a symbol exactly is chosen. For example, 1111000110010 gives (7,10), (1,9), (3,4), (1,1), and 1001101011 gives (9,6), (5,3), (3,0).
- R5: Fragments come out in MSB-first order, and leading zeros are skipped. For example, 011010 gives (3,3), (1,1).
- R6: The shifted symbols of one run add up to the coefficient. Their nonzero-bit counts add up to the coefficient's nonzero-bit count.
- R7: `frag_last_o` is high only on the final beat of a run. `busy_o` stays high until that beat and is low in the next cycle.
- R8: A zero coefficient produces exactly one beat, with `frag_empty_o`=1, `frag_last_o`=1, symbol 0 and shift 0.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running decomposition goes on unchanged.
- R10: Near bit 0 the window is limited to the bits that exist. For example, 1 gives (1,0), 10 gives (1,1), and 11 gives (3,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load request, honoured only while idle |
| coef_i | input | W | Coefficient to decompose |
| busy_o | output | 1 | A decomposition is in progress |
| frag_valid_o | output | 1 | Fragment beat valid |
| frag_sym_o | output | 4 | Symbol pattern value (0 on an empty beat) |
| frag_shift_o | output | $clog2(W) | LSB position of the window |
| frag_last_o | output | 1 | Final beat of the run |
| frag_empty_o | output | 1 | Coefficient was zero |

## Verification
The assertions take some things for granted. The top set bit reported by the priority encoder is assumed to be set in the residue, and each step is assumed to clear only bits that were already set, so the residue strictly shrinks. A start request that arrives during a run must not bring in new bits. The stimulus drives `start_i` and `coef_i` only on falling edges and holds them for a full cycle. It sends a second start request only in the middle of a run, so the ignore rule is exercised without ever leaving the block in an undefined load state.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int unsigned SYM_W = 4;
  localparam logic [SYM_W-1:0] SYM_ONE  = 4'd1;
  localparam logic [SYM_W-1:0] SYM_THR  = 4'd3;
  localparam logic [SYM_W-1:0] SYM_FIV  = 4'd5;
  localparam logic [SYM_W-1:0] SYM_SEV  = 4'd7;
  localparam logic [SYM_W-1:0] SYM_NIN  = 4'd9;

  function automatic logic sym_ok(input logic [SYM_W-1:0] win, input int unsigned w);
    case (w)
      4:       sym_ok = (win == SYM_NIN);
      3:       sym_ok = (win == SYM_FIV) || (win == SYM_SEV);
      2:       sym_ok = (win == SYM_THR);
      1:       sym_ok = (win == SYM_ONE);
      default: sym_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lsg_top_finder.sv
module lsg_top_finder #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [SW-1:0] pos_o
);
  always_comb begin
    any_o = 1'b0;
    pos_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        pos_o = SW'(i);
      end
    end
  end

  always_comb begin
    if (any_o) AST_POS_SET: assert (vec_i[pos_o]); // R5
  end
endmodule

// File: rtl/lsg_window_match.sv
module lsg_window_match
  import lsg_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]     res_i,
  input  logic             any_i,
  input  logic [SW-1:0]    pos_i,
  output logic [SYM_W-1:0] sym_o,
  output logic [SW-1:0]    shift_o
);
  always_comb begin
    logic found;
    logic [SYM_W-1:0] win;
    int lsb;
    found   = 1'b0;
    sym_o   = '0;
    shift_o = '0;
    win     = '0;
    lsb     = 0;
    for (int w = 4; w >= 1; w--) begin
      if (!found && any_i && (int'(pos_i) >= w - 1)) begin
        lsb = int'(pos_i) - (w - 1);
        win = SYM_W'(res_i >> lsb) & SYM_W'((1 << w) - 1);
        if (sym_ok(win, w)) begin
          found   = 1'b1;
          sym_o   = win;
          shift_o = SW'(lsb);
        end
      end
    end
  end

  always_comb begin
    if (any_i) AST_SYM_LEGAL: assert (sym_o == SYM_ONE || sym_o == SYM_THR ||
                                      sym_o == SYM_FIV || sym_o == SYM_SEV ||
                                      sym_o == SYM_NIN); // R3
  end
endmodule

// File: rtl/lsg_decomposer.sv
module lsg_decomposer
  import lsg_pkg::*;
#(
  parameter int unsigned W  = 16,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [W-1:0]     coef_i,
  output logic             busy_o,
  output logic             frag_valid_o,
  output logic [SYM_W-1:0] frag_sym_o,
  output logic [SW-1:0]    frag_shift_o,
  output logic             frag_last_o,
  output logic             frag_empty_o
);
  logic             busy_q;
  logic [W-1:0]     res_q, res_nxt;
  logic             any;
  logic [SW-1:0]    top_pos;
  logic [SYM_W-1:0] sym;
  logic [SW-1:0]    shift;
  logic             last;

  lsg_top_finder #(.W(W), .SW(SW)) u_top (
    .vec_i (res_q),
    .any_o (any),
    .pos_o (top_pos)
  );

  lsg_window_match #(.W(W), .SW(SW)) u_match (
    .res_i   (res_q),
    .any_i   (any),
    .pos_i   (top_pos),
    .sym_o   (sym),
    .shift_o (shift)
  );

  // covered zeros are already zero, so xor clears exactly the window's ones
  assign res_nxt = res_q ^ (W'(sym) << shift);
  assign last    = busy_q && (res_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      res_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        res_q  <= coef_i;
      end
    end else begin
      res_q <= res_nxt;
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy_o       = busy_q;
  assign frag_valid_o = busy_q;
  assign frag_sym_o   = (busy_q && any) ? sym : '0;
  assign frag_shift_o = (busy_q && any) ? shift : '0;
  assign frag_last_o  = last;
  assign frag_empty_o = busy_q && !any;

  AST_LAST_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o && frag_last_o |=> !busy_o); // R7
  AST_HOLD_TO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !frag_last_o |=> busy_o && frag_valid_o); // R2
  AST_RES_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> (res_q < $past(res_q)) && ((res_q & ~$past(res_q)) == '0)); // R6
  AST_EMPTY_IS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_empty_o |-> frag_last_o && (frag_sym_o == '0)); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last && start_i |=> busy_q && ((res_q & ~$past(res_q)) == '0)); // R9
endmodule

// File: tb/lsg_decomposer_test.sv
`timescale 1ns/1ps
module lsg_decomposer_test;
  localparam int W  = 16;
  localparam int SW = $clog2(W);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  coef_i = '0;
  logic          busy_o, frag_valid_o, frag_last_o, frag_empty_o;
  logic [3:0]    frag_sym_o;
  logic [SW-1:0] frag_shift_o;

  int n_chk = 0;
  int n_err = 0;

  int got_sym [0:W];
  int got_sh  [0:W];
  int got_n;
  int got_empty;
  int exp_sym [0:W];
  int exp_sh  [0:W];
  int exp_n;

  always #2.5 clk_i = ~clk_i;

  lsg_decomposer #(.W(W)) uut (
    .clk_i, .rst_ni, .start_i, .coef_i, .busy_o, .frag_valid_o,
    .frag_sym_o, .frag_shift_o, .frag_last_o, .frag_empty_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // greedy widest-first model built from R4/R10
  task automatic ref_model(input int coef);
    int r;
    r = coef;
    exp_n = 0;
    while (r != 0) begin
      int p;
      int done;
      p = 0;
      for (int i = 0; i < W; i++) if (r[i]) p = i;
      done = 0;
      for (int w = 4; w >= 1; w--) begin
        if (!done && p >= w - 1) begin
          int win;
          win = (r >> (p - w + 1)) & ((1 << w) - 1);
          if ((w == 4 && win == 9) || (w == 3 && (win == 5 || win == 7)) ||
              (w == 2 && win == 3) || w == 1) begin
            exp_sym[exp_n] = win;
            exp_sh[exp_n]  = p - w + 1;
            exp_n++;
            r = r ^ (win << (p - w + 1));
            done = 1;
          end
        end
      end
    end
  endtask

  // start at negedge, then collect beats at negedges; optional mid-run start
  task automatic run(input int coef, input int poke_at, input int poke_coef);
    int cyc;
    @(negedge clk_i);
    start_i = 1'b1;
    coef_i  = W'(coef);
    @(negedge clk_i);
    start_i = 1'b0;
    coef_i  = '0;
    got_n = 0;
    got_empty = 0;
    cyc = 0;
    while (cyc < 2 * W) begin
      chk("R2 valid each cycle", int'(frag_valid_o), 1);
      got_sym[got_n] = int'(frag_sym_o);
      got_sh[got_n]  = int'(frag_shift_o);
      got_empty      = int'(frag_empty_o);
      got_n++;
      if (frag_last_o) break;
      if (cyc == poke_at) begin
        start_i = 1'b1;
        coef_i  = W'(poke_coef);
      end
      @(negedge clk_i);
      start_i = 1'b0;
      coef_i  = '0;
      cyc++;
    end
    @(negedge clk_i);
    chk("R7 busy low after last", int'(busy_o), 0);
  endtask

  task automatic compare(input string req);
    int sum, pc;
    chk({req, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk({req, " sym"}, got_sym[i], exp_sym[i]);
      chk({req, " shift"}, got_sh[i], exp_sh[i]);
    end
    sum = 0;
    pc = 0;
    for (int i = 0; i < got_n; i++) begin
      sum += got_sym[i] << got_sh[i];
      pc  += $countones(got_sym[i]);
    end
    chk("R6 fragment sum", sum, exp_n == 0 ? 0 : sum_of_exp());
    chk("R6 popcount", pc, pop_of_exp());
  endtask

  function automatic int sum_of_exp();
    int s;
    s = 0;
    for (int i = 0; i < exp_n; i++) s += exp_sym[i] << exp_sh[i];
    return s;
  endfunction

  function automatic int pop_of_exp();
    int s;
    s = 0;
    for (int i = 0; i < exp_n; i++) s += $countones(exp_sym[i]);
    return s;
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 valid after reset", int'(frag_valid_o), 0);
  endtask

  task automatic t_long_window();
    run(16'b1001101011, -1, 0);
    exp_n = 3;
    exp_sym[0] = 9; exp_sh[0] = 6;
    exp_sym[1] = 5; exp_sh[1] = 3;
    exp_sym[2] = 3; exp_sh[2] = 0;
    compare("R4 1001101011");
    chk("R6 sum equals coef", sum_of_exp(), 16'b1001101011);
  endtask

  task automatic t_reject_1111();
    run(16'b1111000110010, -1, 0);
    exp_n = 4;
    exp_sym[0] = 7; exp_sh[0] = 10;
    exp_sym[1] = 1; exp_sh[1] = 9;
    exp_sym[2] = 3; exp_sh[2] = 4;
    exp_sym[3] = 1; exp_sh[3] = 1;
    compare("R4 1111 rejected");
    chk("R3 first symbol is 7", got_sym[0], 7);
  endtask

  task automatic t_leading_zeros();
    run(16'b011010, -1, 0);
    exp_n = 2;
    exp_sym[0] = 3; exp_sh[0] = 3;
    exp_sym[1] = 1; exp_sh[1] = 1;
    compare("R5 leading zeros");
  endtask

  task automatic t_zero();
    run(0, -1, 0);
    chk("R8 one beat", got_n, 1);
    chk("R8 empty flag", got_empty, 1);
    chk("R8 sym zero", got_sym[0], 0);
    chk("R8 shift zero", got_sh[0], 0);
  endtask

  task automatic t_low_edge();
    run(1, -1, 0);
    chk("R10 coef 1 count", got_n, 1);
    chk("R10 coef 1 sym", got_sym[0], 1);
    chk("R10 coef 1 shift", got_sh[0], 0);
    run(2, -1, 0);
    chk("R10 coef 10 sym", got_sym[0], 1);
    chk("R10 coef 10 shift", got_sh[0], 1);
    run(3, -1, 0);
    chk("R10 coef 11 sym", got_sym[0], 3);
    chk("R10 coef 11 shift", got_sh[0], 0);
    chk("R10 coef 11 count", got_n, 1);
  endtask

  task automatic t_ignore_start();
    ref_model(16'hB5AD);
    run(16'hB5AD, 1, 16'hFFFF);
    compare("R9 start while busy");
  endtask

  task automatic t_sweep();
    int vals [0:5] = '{16'hFFFF, 16'h8001, 16'h9249, 16'hAAAA, 16'h7777, 16'h1234};
    foreach (vals[k]) begin
      ref_model(vals[k]);
      run(vals[k], -1, 0);
      compare("R4 sweep");
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_long_window();
    t_reject_1111();
    t_leading_zeros();
    t_zero();
    t_low_edge();
    t_ignore_start();
    t_sweep();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule